// File: doc/BRIEF.md
# Clock-Calendar Alarm Interrupt and Control/Status Registers

This block holds the control register and the read-only status register of a clock-calendar peripheral and drives its alarm interrupt pin. A host reaches both registers over a simple parallel bus with an address, write data, a read strobe and a write strobe. Read data comes back registered, one clock after the read strobe.

The control register stores several fields:
- an alarm interrupt enable bit;
- a two-bit converter input select;
- a write-protect bit;
- an oscillator enable bit;
- a two-bit trickle field.

The status register reports three things: the update-in-progress level taken straight from an input, a low-battery flag, and the alarm interrupt flag. The low-battery flag has hysteresis and is fed by two supply comparators.

The interrupt flag is set by an alarm-match pulse from the timekeeping logic. It is cleared as a side effect of any bus access to the alarm register window. The interrupt pin is the flag gated by the enable bit.

Top module: `rtc_alarm_regs`

## Requirements
- R1: After reset the control register reads 0x70, which means trickle = 11, oscillator enable = 1, write-protect = 0, input select = 00 and interrupt enable = 0. The status register reads 0x00 and `irq_out` is 0.
- R2: A write to `CTRL_ADDR` stores `bus_wdata[6:0]`. The register layout is as follows:
  - bits 6:5: trickle;
  - bit 4: oscillator enable;
  - bit 3: write-protect;
  - bits 2:1: input select (00 none, 01 input 0, 10 input 1, 11 input 2);
  - bit 0: interrupt enable.
  Bit 7 always reads 0.
- R3: The status register at `STAT_ADDR` reads as follows:
  - bit 7: `upd_busy`, sampled in the read cycle;
  - bit 6: the low-battery flag;
  - bits 5:1: always 0;
  - bit 0: the interrupt flag.
- R4: A cycle with `alarm_match` high sets the interrupt flag. The flag stays set until it is cleared.
- R5: `irq_out` is 1 in the cycle after the interrupt flag and the interrupt enable are both 1. Otherwise it is 0.
- R6: A read or a write to any address in `ALM_LO`..`ALM_HI`, bounds included, clears the interrupt flag. Accesses to other addresses leave it unchanged.
- R7: When a clearing access and `alarm_match` fall in the same cycle, the flag ends up cleared.
- R8: The low-battery flag works as follows:
  - It becomes 1 after a cycle with `bat_below_lo` high.
  - It becomes 0 after a cycle with only `bat_above_hi` high.
  - With both inputs low it holds its value.
- R9: Writes to the status address change nothing.
- R10: `bus_rdata` updates one cycle after a read strobe and holds between reads. Reads of unmapped addresses, the alarm window among them, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| alarm_match | input | 1 | Time matched alarm, one-cycle pulse |
| upd_busy | input | 1 | Update-in-progress level |
| bat_above_hi | input | 1 | Backup supply above upper threshold |
| bat_below_lo | input | 1 | Backup supply below lower threshold |
| irq_out | output | 1 | Alarm interrupt, active high |
| bus_rdata | output | 8 | Registered read data |

## Verification
A flag left stuck set or stuck clear shows on `irq_out` one cycle after the state goes wrong, provided the enable is set. It also shows in bit 0 of the next status read. A wrong hysteresis state shows in bit 6 of the first status read after the comparator inputs change. A wrong stored control value shows on the first read-back. Because of this, the bench follows every stimulus with an idle cycle and then samples both outputs, so each fault becomes visible within two clocks.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic       rsvd;
    logic [1:0] trickle;
    logic       osc_en;
    logic       wprot;
    logic [1:0] ain_sel;
    logic       alarm_ie;
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 8'h7F;
  localparam ctrl_t CTRL_RST = '{rsvd: 1'b0, trickle: 2'b11, osc_en: 1'b1,
                                 wprot: 1'b0, ain_sel: 2'b00, alarm_ie: 1'b0};
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_t'(wdata & CTRL_WMASK);
  end

  // R2: a write lands with the reserved bit forced low
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q == ctrl_t'($past(wdata) & CTRL_WMASK)));
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_access,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (clr_access) flag_q <= 1'b0;   // clear has priority
    else if (set_pulse)  flag_q <= 1'b1;
  end

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    clr_access |=> !flag_q);
  assert_set_R4: assert property (@(posedge clk) disable iff (rst)
    (set_pulse && !clr_access) |=> flag_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_access) |=> flag_q);
endmodule

// File: rtl/rtc_lobat_hyst.sv
module rtc_lobat_hyst (
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  output logic lobat_q
);
  always_ff @(posedge clk) begin
    if (rst)           lobat_q <= 1'b0;
    else if (below_lo) lobat_q <= 1'b1;
    else if (above_hi) lobat_q <= 1'b0;
  end

  assert_low_sets_R8: assert property (@(posedge clk) disable iff (rst)
    below_lo |=> lobat_q);
  assert_high_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (above_hi && !below_lo) |=> !lobat_q);
  assert_band_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!above_hi && !below_lo) |=> $stable(lobat_q));
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 11,
  parameter int unsigned STAT_ADDR = 12,
  parameter int unsigned ALM_LO    = 1,
  parameter int unsigned ALM_HI    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              alarm_match,
  input  logic              upd_busy,
  input  logic              bat_above_hi,
  input  logic              bat_below_lo,
  output logic              irq_out,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAT = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ALO  = ALM_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_AHI  = ALM_HI[ADDR_W-1:0];

  ctrl_t ctrl_q;
  logic  irqf_q, lobat_q;
  logic  ctrl_wr, alm_access;
  logic [DATA_W-1:0] status_w, rd_mux;

  assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
  assign alm_access = (bus_rd || bus_wr) && (bus_addr >= A_ALO) && (bus_addr <= A_AHI);

  rtc_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(bus_wdata), .ctrl_q(ctrl_q)
  );

  rtc_irq_flag u_flag (
    .clk(clk), .rst(rst), .set_pulse(alarm_match), .clr_access(alm_access), .flag_q(irqf_q)
  );

  rtc_lobat_hyst u_lobat (
    .clk(clk), .rst(rst), .above_hi(bat_above_hi), .below_lo(bat_below_lo), .lobat_q(lobat_q)
  );

  assign status_w = {upd_busy, lobat_q, 5'b00000, irqf_q};

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL)      rd_mux = ctrl_q;
    else if (bus_addr == A_STAT) rd_mux = status_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_out <= irqf_q && ctrl_q.alarm_ie;
    end
  end

  assert_irq_on_R5: assert property (@(posedge clk) disable iff (rst)
    (irqf_q && ctrl_q.alarm_ie) |=> irq_out);
  assert_irq_off_R5: assert property (@(posedge clk) disable iff (rst)
    !(irqf_q && ctrl_q.alarm_ie) |=> !irq_out);
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  assert_status_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> (bus_rdata[5:1] == 5'b00000));
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL) |=> !bus_rdata[7]);
endmodule

// File: tb/rtc_alarm_regs_tb.sv
module rtc_alarm_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic       alarm_match = 1'b0, upd_busy = 1'b0;
  logic       bat_above_hi = 1'b0, bat_below_lo = 1'b0;
  logic       irq_out;
  logic [7:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  rtc_alarm_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .alarm_match(alarm_match),
    .upd_busy(upd_busy), .bat_above_hi(bat_above_hi), .bat_below_lo(bat_below_lo),
    .irq_out(irq_out), .bus_rdata(bus_rdata)
  );

  // vector: op(2: 0 idle,1 rd,2 wr) addr(4) wdata(8) match busy hi lo chk_rd exp_rd(8) exp_irq
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {2'd1,4'hB,8'h00,4'b0000,1'b1,8'h70,1'b0},  // 0  R1 reset ctrl
    {2'd2,4'hB,8'hFF,4'b0000,1'b0,8'h00,1'b0},  // 1  R2 write all ones
    {2'd1,4'hB,8'h00,4'b0000,1'b1,8'h7F,1'b0},  // 2  R2 bit7 reads 0
    {2'd0,4'h0,8'h00,4'b1000,1'b0,8'h00,1'b1},  // 3  R4 R5 match -> irq
    {2'd1,4'hC,8'h00,4'b0100,1'b1,8'h81,1'b1},  // 4  R3 busy + flag
    {2'd2,4'hC,8'h00,4'b0000,1'b0,8'h00,1'b1},  // 5  R9 status write ignored
    {2'd1,4'h4,8'h00,4'b0000,1'b1,8'h00,1'b1},  // 6  R6 R10 outside window
    {2'd1,4'h2,8'h00,4'b0000,1'b1,8'h00,1'b0},  // 7  R6 read in window clears
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h00,1'b0},  // 8  R6 flag gone
    {2'd0,4'h0,8'h00,4'b1000,1'b0,8'h00,1'b1},  // 9  R4 set again
    {2'd2,4'hB,8'h70,4'b0000,1'b0,8'h00,1'b0},  // 10 R5 enable off masks
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h01,1'b0},  // 11 R5 flag still set
    {2'd2,4'h1,8'h5A,4'b1000,1'b0,8'h00,1'b0},  // 12 R7 clear beats match
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h00,1'b0},  // 13 R7 flag clear
    {2'd0,4'h0,8'h00,4'b0001,1'b0,8'h00,1'b0},  // 14 R8 below low
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h40,1'b0},  // 15 R8 lobat set
    {2'd0,4'h0,8'h00,4'b0000,1'b0,8'h00,1'b0},  // 16 R8 in band
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h40,1'b0},  // 17 R8 held
    {2'd0,4'h0,8'h00,4'b0010,1'b0,8'h00,1'b0},  // 18 R8 above high
    {2'd1,4'hC,8'h00,4'b0000,1'b1,8'h00,1'b0},  // 19 R8 cleared
    {2'd2,4'hB,8'h01,4'b0000,1'b0,8'h00,1'b0},  // 20 R2 enable only
    {2'd0,4'h0,8'h00,4'b1000,1'b0,8'h00,1'b1},  // 21 R5 irq
    {2'd2,4'h3,8'h00,4'b0000,1'b0,8'h00,1'b0},  // 22 R6 write at upper bound
    {2'd1,4'hB,8'h00,4'b0000,1'b1,8'h01,1'b0}   // 23 R2 read back
  };
  string VREQ [NV] = '{"R1","R2","R2","R5","R3","R9","R10","R6","R6","R4","R5","R5",
                       "R7","R7","R8","R8","R8","R8","R8","R8","R2","R5","R6","R2"};

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_rd = 1'b0; bus_wr = 1'b0; alarm_match = 1'b0;
    bat_above_hi = 1'b0; bat_below_lo = 1'b0;
  endtask

  initial begin
    #200000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "irq after reset", {7'd0, irq_out}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      bus_rd = (v[27:26] == 2'd1);
      bus_wr = (v[27:26] == 2'd2);
      bus_addr = v[25:22];
      bus_wdata = v[21:14];
      alarm_match = v[13];
      upd_busy = v[12];
      bat_above_hi = v[11];
      bat_below_lo = v[10];
      @(negedge clk);
      idle_bus();
      upd_busy = 1'b0;
      @(negedge clk);
      if (v[9]) check(VREQ[i], $sformatf("vec %0d rdata", i), bus_rdata, v[8:1]);
      check(VREQ[i], $sformatf("vec %0d irq", i), {7'd0, irq_out}, {7'd0, v[0]});
    end

    // R10: read data visible exactly one cycle after the strobe
    bus_rd = 1'b1; bus_addr = 4'hC; upd_busy = 1'b1;
    @(negedge clk);
    idle_bus(); upd_busy = 1'b0;
    check("R10", "one-cycle latency", bus_rdata, 8'h80);
    @(negedge clk);
    check("R10", "rdata holds", bus_rdata, 8'h80);

    // R8: both comparator inputs high -> low side wins
    bat_above_hi = 1'b1; bat_below_lo = 1'b1;
    @(negedge clk);
    idle_bus(); bus_rd = 1'b1; bus_addr = 4'hC;
    @(negedge clk);
    idle_bus();
    check("R8", "below wins", bus_rdata, 8'h40);

    // R1: reset mid-run restores defaults
    bus_wr = 1'b1; bus_addr = 4'hB; bus_wdata = 8'h0F; alarm_match = 1'b1;
    @(negedge clk);
    idle_bus();
    @(negedge clk);
    check("R5", "irq before reset", {7'd0, irq_out}, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "irq after reset", {7'd0, irq_out}, 8'h00);
    bus_rd = 1'b1; bus_addr = 4'hB;
    @(negedge clk);
    bus_addr = 4'hC;
    check("R1", "ctrl after reset", bus_rdata, 8'h70);
    @(negedge clk);
    idle_bus();
    check("R1", "status after reset", bus_rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule